// File: doc/BRIEF.md
# Memory Pattern Scheduler

This block decides which precomputed SDRAM command pattern the pattern sequencer runs next. It chooses among five pattern kinds: read, write, read-to-write bus turnaround, write-to-read bus turnaround and refresh. Each pattern is treated as an indivisible unit. Once a pattern starts, nothing is decided until the sequencer reports that it has finished.

A single requestor offers accesses through a valid/ready pair with a direction bit. The scheduler keeps the direction of the last access pattern. When a request would reverse the bus, it runs the matching turnaround pattern first and then the access pattern. An internal timer raises a refresh request every `REFI_CYCLES` cycles. The request stays latched until a refresh pattern starts. Refresh wins over a waiting access at the next legal decision point, but it is never placed between a turnaround and the access it prepares.

All outputs are registered. A decision made in a cycle with no pattern in flight appears on the next clock edge as a one-cycle start strobe, carrying the pattern code.

Top module: `mem_pattern_sched`

## Requirements
- R1: While a pattern is in flight (from its start strobe until `pat_done` is sampled), `pat_start` and `req_ready` stay low, whatever requests or refresh events occur.
- R2: The first access after reset, and any access in the same direction as the last access pattern, starts directly with no turnaround pattern.
- R3: A write request whose last access pattern was a read produces a read-to-write pattern and then, as the very next pattern, a write pattern.
- R4: A read request whose last access pattern was a write produces a write-to-read pattern and then, as the very next pattern, a read pattern.
- R5: A refresh request is raised every `REFI_CYCLES` cycles and stays latched until a refresh pattern starts. With no traffic, a refresh pattern starts within a few cycles of the request, and one refresh request yields exactly one refresh pattern.
- R6: When a refresh is pending and an access request is waiting at the same decision point, the refresh pattern starts first and the access follows it.
- R7: A refresh pattern never starts directly after a turnaround pattern. The access pattern the turnaround prepared runs first, and the refresh runs after it.
- R8: A refresh pattern does not change the remembered bus direction. After read, refresh, write, the sequence still contains a read-to-write pattern.
- R9: `idle` is high after reset and whenever no pattern is in flight. It is low from the start strobe until the cycle after `pat_done` is sampled.
- R10: `pat_start` and `req_ready` are one-cycle pulses. `req_ready` coincides with the start of the pattern that serves the request, which is either the access itself or its turnaround. The `pat_kind` codes are 0 read, 1 write, 2 read-to-write, 3 write-to-read and 4 refresh.
- R11: A latched refresh request is served within 8·`REFI_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request offered, held until accepted |
| req_is_write | input | 1 | Request direction: 1 write, 0 read |
| req_ready | output | 1 | One-cycle acceptance of the offered request |
| pat_done | input | 1 | Pulse from the sequencer: the running pattern has finished |
| pat_start | output | 1 | One-cycle strobe: start the pattern in `pat_kind` |
| pat_kind | output | 3 | Pattern code, valid with `pat_start` |
| idle | output | 1 | High when no pattern is in flight |

## Verification
A corrupted remembered direction shows up at the start strobe of the next access. The bench sees either a turnaround that is missing or one it did not ask for, or a turnaround followed by the wrong access. A lost or stuck refresh latch shows as a missing refresh pattern, or as an extra one, within about one timer interval of the tick. A broken in-flight flag shows as a start strobe or ready pulse while the sequencer is still holding a pattern. The bench stalls the sequencer deliberately to expose that window.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic [2:0] {
    PK_READ    = 3'd0,
    PK_WRITE   = 3'd1,
    PK_RD2WR   = 3'd2,
    PK_WR2RD   = 3'd3,
    PK_REFRESH = 3'd4
  } pat_kind_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_RD   = 2'd1,
    DIR_WR   = 2'd2
  } bus_dir_e;
endpackage

// File: rtl/mps_refresh_timer.sv
module mps_refresh_timer #(
  parameter int unsigned REFI_CYCLES = 975
) (
  input  logic clk,
  input  logic rst,
  input  logic served,
  output logic pending
);
  localparam int unsigned CNT_W  = (REFI_CYCLES > 1) ? $clog2(REFI_CYCLES) : 1;
  localparam int unsigned BOUND  = 8 * REFI_CYCLES;
  localparam int unsigned WAIT_W = $clog2(BOUND + 1);

  logic [CNT_W-1:0]  cnt;
  logic              tick;
  logic [WAIT_W-1:0] wait_cnt;

  assign tick = (cnt == CNT_W'(REFI_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // A new tick keeps the latch set even when it coincides with service.
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else if (tick) begin
      pending <= 1'b1;
    end else if (served) begin
      pending <= 1'b0;
    end
  end

  // Age of the outstanding refresh, saturating at the bound.
  always_ff @(posedge clk) begin
    if (rst || !pending) begin
      wait_cnt <= '0;
    end else if (wait_cnt != WAIT_W'(BOUND)) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  a_r11_refresh_bound: assert property (@(posedge clk) disable iff (rst)
    wait_cnt < WAIT_W'(BOUND));

  a_r5_served_only_pending: assert property (@(posedge clk) disable iff (rst)
    served |-> pending);
endmodule

// File: rtl/mps_dir_tracker.sv
module mps_dir_tracker
  import mps_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      go,
  input  pat_kind_e kind,
  output bus_dir_e  last_dir
);
  // Only access patterns move the remembered direction. Refresh and
  // turnaround patterns leave it unchanged.
  always_ff @(posedge clk) begin
    if (rst) begin
      last_dir <= DIR_NONE;
    end else if (go && kind == PK_READ) begin
      last_dir <= DIR_RD;
    end else if (go && kind == PK_WRITE) begin
      last_dir <= DIR_WR;
    end
  end

  a_r3_rd2wr_from_read: assert property (@(posedge clk) disable iff (rst)
    (go && kind == PK_RD2WR) |-> last_dir == DIR_RD);

  a_r4_wr2rd_from_write: assert property (@(posedge clk) disable iff (rst)
    (go && kind == PK_WR2RD) |-> last_dir == DIR_WR);
endmodule

// File: rtl/mps_pattern_picker.sv
module mps_pattern_picker
  import mps_pkg::*;
(
  input  logic      in_flight,
  input  logic      pend_v,
  input  bus_dir_e  pend_dir,
  input  logic      ref_pend,
  input  logic      req_valid,
  input  logic      req_is_write,
  input  bus_dir_e  last_dir,
  output logic      go,
  output pat_kind_e kind,
  output logic      take_req,
  output logic      pend_set,
  output bus_dir_e  pend_dir_new,
  output logic      ref_served
);
  bus_dir_e want;

  always_comb begin
    want         = req_is_write ? DIR_WR : DIR_RD;
    go           = 1'b0;
    kind         = PK_READ;
    take_req     = 1'b0;
    pend_set     = 1'b0;
    pend_dir_new = DIR_NONE;
    ref_served   = 1'b0;
    if (!in_flight) begin
      if (pend_v) begin
        // A turnaround has just finished: its access must follow.
        go   = 1'b1;
        kind = (pend_dir == DIR_WR) ? PK_WRITE : PK_READ;
      end else if (ref_pend) begin
        go         = 1'b1;
        kind       = PK_REFRESH;
        ref_served = 1'b1;
      end else if (req_valid) begin
        go       = 1'b1;
        take_req = 1'b1;
        if (last_dir == DIR_NONE || last_dir == want) begin
          kind = (want == DIR_WR) ? PK_WRITE : PK_READ;
        end else begin
          kind         = (want == DIR_WR) ? PK_RD2WR : PK_WR2RD;
          pend_set     = 1'b1;
          pend_dir_new = want;
        end
      end
    end
  end
endmodule

// File: rtl/mem_pattern_sched.sv
module mem_pattern_sched #(
  parameter int unsigned REFI_CYCLES = 975
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_is_write,
  output logic       req_ready,
  input  logic       pat_done,
  output logic       pat_start,
  output logic [2:0] pat_kind,
  output logic       idle
);
  import mps_pkg::*;

  logic      busy;
  logic      pend_v;
  bus_dir_e  pend_dir;
  bus_dir_e  last_dir;
  logic      ref_pend;
  logic      go;
  pat_kind_e kind_nxt;
  logic      take_req;
  logic      pend_set;
  bus_dir_e  pend_dir_new;
  logic      ref_served;

  mps_refresh_timer #(.REFI_CYCLES(REFI_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .served  (ref_served),
    .pending (ref_pend)
  );

  mps_dir_tracker u_dir (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .kind     (kind_nxt),
    .last_dir (last_dir)
  );

  mps_pattern_picker u_pick (
    .in_flight    (busy),
    .pend_v       (pend_v),
    .pend_dir     (pend_dir),
    .ref_pend     (ref_pend),
    .req_valid    (req_valid),
    .req_is_write (req_is_write),
    .last_dir     (last_dir),
    .go           (go),
    .kind         (kind_nxt),
    .take_req     (take_req),
    .pend_set     (pend_set),
    .pend_dir_new (pend_dir_new),
    .ref_served   (ref_served)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pat_start <= 1'b0;
      pat_kind  <= 3'd0;
      req_ready <= 1'b0;
      idle      <= 1'b1;
      pend_v    <= 1'b0;
      pend_dir  <= DIR_NONE;
    end else begin
      pat_start <= go;
      req_ready <= take_req;
      if (go) begin
        pat_kind <= kind_nxt;
      end
      busy <= go ? 1'b1 : (pat_done ? 1'b0 : busy);
      idle <= !(go || (busy && !pat_done));
      if (go && pend_v) begin
        pend_v <= 1'b0;
      end else if (pend_set) begin
        pend_v   <= 1'b1;
        pend_dir <= pend_dir_new;
      end
    end
  end

  // Kind of the previously started pattern, kept for checking only.
  logic [2:0] prev_kind;
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_kind <= 3'(PK_REFRESH);
    end else if (pat_start) begin
      prev_kind <= pat_kind;
    end
  end

  a_r1_no_start_in_flight: assert property (@(posedge clk) disable iff (rst)
    (busy && !pat_done) |=> (!pat_start && !req_ready));

  a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
    pat_start |=> !pat_start);

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  a_r3_write_after_rd2wr: assert property (@(posedge clk) disable iff (rst)
    (pat_start && prev_kind == 3'(PK_RD2WR)) |-> pat_kind == 3'(PK_WRITE));

  a_r4_read_after_wr2rd: assert property (@(posedge clk) disable iff (rst)
    (pat_start && prev_kind == 3'(PK_WR2RD)) |-> pat_kind == 3'(PK_READ));

  a_r7_no_refresh_after_switch: assert property (@(posedge clk) disable iff (rst)
    (pat_start && (prev_kind == 3'(PK_RD2WR) || prev_kind == 3'(PK_WR2RD)))
      |-> pat_kind != 3'(PK_REFRESH));

  a_r9_idle_vs_start: assert property (@(posedge clk) disable iff (rst)
    pat_start |-> !idle);
endmodule

// File: tb/mem_pattern_sched_test.sv
`timescale 1ns/1ps
module mem_pattern_sched_test;
  localparam int REFI     = 400;
  localparam int DONE_LAT = 3;
  localparam int K_RD = 0, K_WR = 1, K_RW = 2, K_WRD = 3, K_REF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_is_write = 1'b0;
  logic pat_done = 1'b0;
  logic req_ready;
  logic pat_start;
  logic [2:0] pat_kind;
  logic idle;

  int checks = 0;
  int fails = 0;
  int log_kind [0:255];
  int log_n = 0;
  bit hold = 1'b0;
  bit busy_viol = 1'b0;
  bit finished = 1'b0;
  bit ready_extra = 1'b0;

  always #4 clk = ~clk;

  mem_pattern_sched #(.REFI_CYCLES(REFI)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_write(req_is_write),
    .req_ready(req_ready), .pat_done(pat_done), .pat_start(pat_start),
    .pat_kind(pat_kind), .idle(idle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sequencer model: logs each start, reports done after DONE_LAT cycles,
  // longer while hold is set, and flags any strobe in between.
  initial begin
    forever begin
      @(negedge clk);
      if (pat_start) begin
        if (log_n < 256) log_kind[log_n] = int'(pat_kind);
        log_n++;
        repeat (DONE_LAT) begin
          @(negedge clk);
          if (pat_start || req_ready) busy_viol = 1'b1;
        end
        while (hold) begin
          @(negedge clk);
          if (pat_start || req_ready) busy_viol = 1'b1;
        end
        pat_done = 1'b1;
        @(negedge clk);
        if (pat_start || req_ready) busy_viol = 1'b1;
        pat_done = 1'b0;
      end
    end
  end

  task automatic send(input bit wr);
    @(negedge clk);
    req_valid = 1'b1;
    req_is_write = wr;
    do @(negedge clk); while (!req_ready);
    @(negedge clk);
    ready_extra = req_ready;
    req_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (idle && !pat_done && !pat_start) q++; else q = 0;
    end
  endtask

  task automatic exp_kind(input int idx, input int k, input string req);
    int act;
    act = (idx < log_n) ? log_kind[idx] : -1;
    check(act == k, req, act, k);
  endtask

  task automatic t_reset();
    check(pat_start == 1'b0, "R10 reset start", int'(pat_start), 0);
    check(req_ready == 1'b0, "R10 reset ready", int'(req_ready), 0);
    check(idle == 1'b1, "R9 reset idle", int'(idle), 1);
  endtask

  task automatic t_first_read();
    int b = log_n;
    send(1'b0);
    check(idle == 1'b0, "R9 idle low in flight", int'(idle), 0);
    check(ready_extra == 1'b0, "R10 ready one cycle", int'(ready_extra), 0);
    wait_quiet();
    exp_kind(b, K_RD, "R2 first read direct");
    check(log_n == b + 1, "R2 first read count", log_n - b, 1);
    check(idle == 1'b1, "R9 idle after done", int'(idle), 1);
  endtask

  task automatic t_same_dir(input bit wr, input string req);
    int b = log_n;
    send(wr);
    wait_quiet();
    exp_kind(b, wr ? K_WR : K_RD, req);
    check(log_n == b + 1, req, log_n - b, 1);
  endtask

  task automatic t_turn(input bit wr, input string req);
    int b = log_n;
    send(wr);
    wait_quiet();
    exp_kind(b, wr ? K_RW : K_WRD, req);
    exp_kind(b + 1, wr ? K_WR : K_RD, req);
    check(log_n == b + 2, req, log_n - b, 2);
  endtask

  task automatic t_nonpreempt();
    int b = log_n;
    hold = 1'b1;
    busy_viol = 1'b0;
    send(1'b0);
    fork
      send(1'b0);
      begin
        repeat (20) @(negedge clk);
        check(log_n == b + 1, "R1 no start while held", log_n - b, 1);
        hold = 1'b0;
      end
    join
    wait_quiet();
    check(busy_viol == 1'b0, "R1 no strobe in flight", int'(busy_viol), 0);
    exp_kind(b, K_RD, "R1 first pattern");
    exp_kind(b + 1, K_RD, "R1 queued pattern");
  endtask

  task automatic sync_refresh(input string req);
    int b = log_n;
    int t = 0;
    bit found = 1'b0;
    while (t < 2 * REFI + 40 && !found) begin
      @(negedge clk);
      t++;
      if (log_n > b && log_kind[log_n-1] == K_REF) found = 1'b1;
    end
    wait_quiet();
    check(found, req, int'(found), 1);
    check(log_n == b + 1, "R5 one refresh per tick", log_n - b, 1);
  endtask

  task automatic t_refresh_priority();
    int b = log_n;
    hold = 1'b1;
    send(1'b1);
    fork
      send(1'b1);
      begin
        repeat (REFI + 10) @(negedge clk);
        hold = 1'b0;
      end
    join
    wait_quiet();
    exp_kind(b, K_WR, "R6 held write");
    exp_kind(b + 1, K_REF, "R6 refresh before queued write");
    exp_kind(b + 2, K_WR, "R6 queued write after refresh");
  endtask

  task automatic t_no_ref_after_switch();
    int b = log_n;
    hold = 1'b1;
    send(1'b0);
    repeat (REFI + 10) @(negedge clk);
    hold = 1'b0;
    wait_quiet();
    exp_kind(b, K_WRD, "R7 turnaround held");
    exp_kind(b + 1, K_RD, "R7 access before refresh");
    exp_kind(b + 2, K_REF, "R7 refresh after access");
    check(log_n == b + 3, "R7 count", log_n - b, 3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_first_read();
    t_same_dir(1'b0, "R2 read after read");
    t_turn(1'b1, "R3 write after read");
    t_same_dir(1'b1, "R2 write after write");
    t_turn(1'b0, "R4 read after write");
    t_nonpreempt();
    sync_refresh("R5 refresh with no traffic");
    t_turn(1'b1, "R8 direction kept across refresh");
    t_refresh_priority();
    sync_refresh("R11 refresh served within bound");
    t_no_ref_after_switch();
    check(idle == 1'b1, "R9 idle at end", int'(idle), 1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule